// File: doc/BRIEF.md
# Ethernet Socket Bring-up Supervisor

This block brings an external network controller into service and keeps watching it. It reaches the controller only through a register-access engine, which takes a request (read or write, 16-bit address, 8-bit data) and returns an acknowledge pulse. Read data comes with that pulse. The block also owns the controller's active-low reset line. After a system reset, it holds the controller in reset for a set number of milliseconds, releases it, and waits a shorter settling time. It then writes the station configuration, opens socket 0 as a TCP listener, and polls the socket status until each step has taken effect.

Once the socket is listening, the block keeps reading the socket status. A connected socket raises the ready flag, and a socket that is only listening lowers it. Any other value is read once more. If the second read is still neither, ready is cleared, the controller is reset again and the whole configuration is written again. All configuration values, register addresses and status codes are parameters. The millisecond timing comes from a clock-frequency parameter.

Top module: `sock_bringup_sup`

## Requirements
- R1: After system reset, `ctrl_rst_n` is low for exactly RESET_MS × (CLK_HZ/1000) clock cycles. During that time `ready` is 0 and `req_valid` is 0.
- R2: After `ctrl_rst_n` rises, no request is made for exactly SETTLE_MS × (CLK_HZ/1000) cycles. The first request is raised in the next cycle.
- R3: Bring-up issues these writes in order, one per acknowledge:
  - station MAC bytes, most significant first, to 0x0009..0x000E;
  - IP bytes to 0x000F..0x0012;
  - subnet-mask bytes to 0x0005..0x0008;
  - gateway bytes to 0x0001..0x0004;
  - RX memory size to 0x001A;
  - TX memory size to 0x001B.
- R4: The socket writes follow next:
  - mode 0x01 (TCP) to 0x0400;
  - port 5000, high byte 0x13 to 0x0404, then low byte 0x88 to 0x0405;
  - OPEN command 0x01 to the command register 0x0401.
  Both memory-size writes carry 0x0A.
- R5: After OPEN, the status register 0x0403 is read repeatedly until a read returns INIT (0x13). No other write happens before that read.
- R6: After INIT, the LISTEN command 0x02 is written to 0x0401. Status is then polled until it returns LISTEN (0x14). `ready` stays 0 for the whole bring-up.
- R7: While supervising, a status read returning ESTABLISHED (0x17) sets `ready`. The new value is visible in the cycle after the acknowledge.
- R8: While supervising, a status read returning LISTEN (0x14) clears `ready` in the cycle after the acknowledge.
- R9: Any other status value is followed by exactly one re-read. If the re-read returns ESTABLISHED or LISTEN, `ready` follows R7 or R8 and no reset occurs.
- R10: If the re-read is also neither code, `ready` drops and `ctrl_rst_n` goes low in the cycle after the acknowledge. The full R1–R6 sequence then repeats, and supervision resumes after it.
- R11: While `req_valid` is high and `req_ack` is low, `req_write`, `req_addr` and `req_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| req_valid | output | 1 | Register access requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Controller register address |
| req_wdata | output | 8 | Write data |
| req_ack | input | 1 | One-cycle completion pulse from the access engine |
| ack_rdata | input | 8 | Read data, valid with `req_ack` |
| ctrl_rst_n | output | 1 | Active-low reset to the network controller |
| ready | output | 1 | Socket connected |

## Verification
Every result is due one clock edge after its cause:
- `ready` and `ctrl_rst_n` change on the edge that takes the acknowledge.
- A new request appears on the edge where a timer expires or the previous access is acknowledged.

The bench drives inputs and samples outputs on the falling edge. It first waits until its responder has counted the acknowledged read. It then samples once, at the next falling edge. Reset and settling lengths are measured by counting falling edges from the triggering event, so a one-cycle error in either length is caught.

// File: rtl/sbs_pkg.sv
// Shared types and default codes for the socket bring-up supervisor.
// Assumes: an 8-bit status/command space on the controller.
package sbs_pkg;

    typedef enum logic [2:0] {
        S_RST_LOW,
        S_SETTLE,
        S_CFG_WR,
        S_OPEN_POLL,
        S_LSN_WR,
        S_LSN_POLL,
        S_SUPERVISE,
        S_RECHECK
    } sbs_state_t;

    localparam logic [7:0] DEF_CODE_INIT      = 8'h13;
    localparam logic [7:0] DEF_CODE_LISTENING = 8'h14;
    localparam logic [7:0] DEF_CODE_EST       = 8'h17;
    localparam logic [7:0] DEF_CMD_OPEN       = 8'h01;
    localparam logic [7:0] DEF_CMD_LISTEN     = 8'h02;

endpackage

// File: rtl/sbs_ms_timer.sv
// Interval timer for the reset-low and settling phases.
// Counts while run is high and reports hit on the last cycle of the
// selected interval; restarts from zero after a hit or when idle.
// Assumes: both interval lengths are at least one cycle.
module sbs_ms_timer #(
    parameter int LONG_CYC  = 50,
    parameter int SHORT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    output logic hit
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Select the interval end for the current phase.
    always_comb begin
        limit = sel_long ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
    end

    assign hit = run && (cnt == limit);

    // Advance the count while running; restart on hit or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_timer_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));

endmodule

// File: rtl/sbs_cfg_rom.sv
// Bring-up write list: maps a step index to the register address and
// data of one configuration write. Steps run MAC, IP, mask, gateway,
// RX size, TX size, socket mode, port high, port low, OPEN command.
// Assumes: multi-byte fields occupy consecutive addresses, MSB first.
module sbs_cfg_rom #(
    parameter int          IDX_W       = 5,
    parameter logic [47:0] STATION_MAC = 48'h02_00_00_00_00_01,
    parameter logic [31:0] STATION_IP  = 32'hC0A8_0002,
    parameter logic [31:0] NET_MASK    = 32'hFFFF_FF00,
    parameter logic [31:0] GATEWAY_IP  = 32'hC0A8_0001,
    parameter logic [7:0]  RX_MEM_CFG  = 8'h0A,
    parameter logic [7:0]  TX_MEM_CFG  = 8'h0A,
    parameter logic [7:0]  SOCK_MODE   = 8'h01,
    parameter logic [15:0] LISTEN_PORT = 16'd5000,
    parameter logic [15:0] REG_MAC     = 16'h0009,
    parameter logic [15:0] REG_IP      = 16'h000F,
    parameter logic [15:0] REG_MASK    = 16'h0005,
    parameter logic [15:0] REG_GATEWAY = 16'h0001,
    parameter logic [15:0] REG_RXMEM   = 16'h001A,
    parameter logic [15:0] REG_TXMEM   = 16'h001B,
    parameter logic [15:0] REG_SMODE   = 16'h0400,
    parameter logic [15:0] REG_SPORT   = 16'h0404,
    parameter logic [15:0] REG_SCMD    = 16'h0401,
    parameter logic [7:0]  CMD_OPEN    = 8'h01
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      addr,
    output logic [7:0]       data
);
    localparam int B_IP   = 6;
    localparam int B_MASK = B_IP + 4;
    localparam int B_GW   = B_MASK + 4;
    localparam int B_RX   = B_GW + 4;
    localparam int B_TX   = B_RX + 1;
    localparam int B_MODE = B_TX + 1;
    localparam int B_PORT = B_MODE + 1;
    localparam int B_OPEN = B_PORT + 2;

    // Decode the step index into one address/data pair.
    always_comb begin
        addr = REG_SCMD;
        data = CMD_OPEN;
        for (int i = 0; i < 6; i++) begin
            if (idx == IDX_W'(i)) begin
                addr = REG_MAC + 16'(i);
                data = STATION_MAC[8*(5-i) +: 8];
            end
        end
        for (int i = 0; i < 4; i++) begin
            if (idx == IDX_W'(B_IP + i)) begin
                addr = REG_IP + 16'(i);
                data = STATION_IP[8*(3-i) +: 8];
            end
            if (idx == IDX_W'(B_MASK + i)) begin
                addr = REG_MASK + 16'(i);
                data = NET_MASK[8*(3-i) +: 8];
            end
            if (idx == IDX_W'(B_GW + i)) begin
                addr = REG_GATEWAY + 16'(i);
                data = GATEWAY_IP[8*(3-i) +: 8];
            end
        end
        for (int i = 0; i < 2; i++) begin
            if (idx == IDX_W'(B_PORT + i)) begin
                addr = REG_SPORT + 16'(i);
                data = LISTEN_PORT[8*(1-i) +: 8];
            end
        end
        if (idx == IDX_W'(B_RX)) begin
            addr = REG_RXMEM;
            data = RX_MEM_CFG;
        end
        if (idx == IDX_W'(B_TX)) begin
            addr = REG_TXMEM;
            data = TX_MEM_CFG;
        end
        if (idx == IDX_W'(B_MODE)) begin
            addr = REG_SMODE;
            data = SOCK_MODE;
        end
        if (idx == IDX_W'(B_OPEN)) begin
            addr = REG_SCMD;
            data = CMD_OPEN;
        end
    end

endmodule

// File: rtl/sbs_status_decode.sv
// Classifies a socket status byte as INIT, LISTEN or ESTABLISHED.
// Assumes: the three codes are distinct.
module sbs_status_decode #(
    parameter logic [7:0] CODE_INIT      = 8'h13,
    parameter logic [7:0] CODE_LISTENING = 8'h14,
    parameter logic [7:0] CODE_EST       = 8'h17
) (
    input  logic [7:0] code,
    output logic       is_init,
    output logic       is_lsn,
    output logic       is_est
);
    // Compare the byte with each known code.
    always_comb begin
        is_init = (code == CODE_INIT);
        is_lsn  = (code == CODE_LISTENING);
        is_est  = (code == CODE_EST);
    end

endmodule

// File: rtl/sock_bringup_sup.sv
// Socket bring-up supervisor (top).
// Flow:
//   1. Pulse the controller reset, then wait for it to settle.
//   2. Write the station configuration and open socket 0.
//   3. Poll the status for INIT, command LISTEN, then poll for LISTEN.
//   4. Supervise: drive ready from the status and re-read an unknown
//      value once. Two unknowns in a row restart from step 1.
// Assumes: the access engine answers each request with one req_ack
// pulse, with read data on ack_rdata in that cycle.
module sock_bringup_sup
    import sbs_pkg::*;
#(
    parameter int          CLK_HZ         = 50_000_000,
    parameter int          RESET_MS       = 50,
    parameter int          SETTLE_MS      = 5,
    parameter logic [47:0] STATION_MAC    = 48'h02_00_00_00_00_01,
    parameter logic [31:0] STATION_IP     = 32'hC0A8_0002,
    parameter logic [31:0] NET_MASK       = 32'hFFFF_FF00,
    parameter logic [31:0] GATEWAY_IP     = 32'hC0A8_0001,
    parameter logic [7:0]  RX_MEM_CFG     = 8'h0A,
    parameter logic [7:0]  TX_MEM_CFG     = 8'h0A,
    parameter logic [7:0]  SOCK_MODE      = 8'h01,
    parameter logic [15:0] LISTEN_PORT    = 16'd5000,
    parameter logic [15:0] REG_MAC        = 16'h0009,
    parameter logic [15:0] REG_IP         = 16'h000F,
    parameter logic [15:0] REG_MASK       = 16'h0005,
    parameter logic [15:0] REG_GATEWAY    = 16'h0001,
    parameter logic [15:0] REG_RXMEM      = 16'h001A,
    parameter logic [15:0] REG_TXMEM      = 16'h001B,
    parameter logic [15:0] REG_SMODE      = 16'h0400,
    parameter logic [15:0] REG_SCMD       = 16'h0401,
    parameter logic [15:0] REG_SSTAT      = 16'h0403,
    parameter logic [15:0] REG_SPORT      = 16'h0404,
    parameter logic [7:0]  CODE_INIT      = DEF_CODE_INIT,
    parameter logic [7:0]  CODE_LISTENING = DEF_CODE_LISTENING,
    parameter logic [7:0]  CODE_EST       = DEF_CODE_EST,
    parameter logic [7:0]  CMD_OPEN       = DEF_CMD_OPEN,
    parameter logic [7:0]  CMD_LISTEN     = DEF_CMD_LISTEN
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        req_valid,
    output logic        req_write,
    output logic [15:0] req_addr,
    output logic [7:0]  req_wdata,
    input  logic        req_ack,
    input  logic [7:0]  ack_rdata,
    output logic        ctrl_rst_n,
    output logic        ready
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int LOW_CYC    = RESET_MS * CYC_PER_MS;
    localparam int SET_CYC    = SETTLE_MS * CYC_PER_MS;
    localparam int NUM_STEPS  = 6 + 4 + 4 + 4 + 2 + 1 + 2 + 1;
    localparam int IDX_W      = $clog2(NUM_STEPS);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_STEPS - 1);

    sbs_state_t       state;
    logic [IDX_W-1:0] step;
    logic             tmr_hit;
    logic             st_init, st_lsn, st_est;
    logic [15:0]      rom_addr;
    logic [7:0]       rom_data;

    sbs_ms_timer #(
        .LONG_CYC (LOW_CYC),
        .SHORT_CYC(SET_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((state == S_RST_LOW) || (state == S_SETTLE)),
        .sel_long(state == S_RST_LOW),
        .hit     (tmr_hit)
    );

    sbs_cfg_rom #(
        .IDX_W      (IDX_W),
        .STATION_MAC(STATION_MAC),
        .STATION_IP (STATION_IP),
        .NET_MASK   (NET_MASK),
        .GATEWAY_IP (GATEWAY_IP),
        .RX_MEM_CFG (RX_MEM_CFG),
        .TX_MEM_CFG (TX_MEM_CFG),
        .SOCK_MODE  (SOCK_MODE),
        .LISTEN_PORT(LISTEN_PORT),
        .REG_MAC    (REG_MAC),
        .REG_IP     (REG_IP),
        .REG_MASK   (REG_MASK),
        .REG_GATEWAY(REG_GATEWAY),
        .REG_RXMEM  (REG_RXMEM),
        .REG_TXMEM  (REG_TXMEM),
        .REG_SMODE  (REG_SMODE),
        .REG_SPORT  (REG_SPORT),
        .REG_SCMD   (REG_SCMD),
        .CMD_OPEN   (CMD_OPEN)
    ) u_rom (
        .idx (step),
        .addr(rom_addr),
        .data(rom_data)
    );

    sbs_status_decode #(
        .CODE_INIT     (CODE_INIT),
        .CODE_LISTENING(CODE_LISTENING),
        .CODE_EST      (CODE_EST)
    ) u_dec (
        .code   (ack_rdata),
        .is_init(st_init),
        .is_lsn (st_lsn),
        .is_est (st_est)
    );

    // Sequence the bring-up phases and supervise the socket status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_RST_LOW;
            step  <= '0;
            ready <= 1'b0;
        end else begin
            case (state)
                S_RST_LOW: begin
                    if (tmr_hit) state <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (tmr_hit) begin
                        state <= S_CFG_WR;
                        step  <= '0;
                    end
                end
                S_CFG_WR: begin
                    if (req_ack) begin
                        if (step == LAST_STEP) state <= S_OPEN_POLL;
                        else                   step  <= step + 1'b1;
                    end
                end
                S_OPEN_POLL: begin
                    if (req_ack && st_init) state <= S_LSN_WR;
                end
                S_LSN_WR: begin
                    if (req_ack) state <= S_LSN_POLL;
                end
                S_LSN_POLL: begin
                    if (req_ack && st_lsn) state <= S_SUPERVISE;
                end
                S_SUPERVISE: begin
                    if (req_ack) begin
                        if (st_est)      ready <= 1'b1;
                        else if (st_lsn) ready <= 1'b0;
                        else             state <= S_RECHECK;
                    end
                end
                S_RECHECK: begin
                    if (req_ack) begin
                        if (st_est) begin
                            ready <= 1'b1;
                            state <= S_SUPERVISE;
                        end else if (st_lsn) begin
                            ready <= 1'b0;
                            state <= S_SUPERVISE;
                        end else begin
                            ready <= 1'b0;
                            state <= S_RST_LOW;
                        end
                    end
                end
                default: state <= S_RST_LOW;
            endcase
        end
    end

    // Drive the access request and the controller reset from the phase.
    always_comb begin
        ctrl_rst_n = (state != S_RST_LOW);
        req_valid  = (state != S_RST_LOW) && (state != S_SETTLE);
        req_write  = (state == S_CFG_WR) || (state == S_LSN_WR);
        req_addr   = REG_SSTAT;
        req_wdata  = 8'h00;
        if (state == S_CFG_WR) begin
            req_addr  = rom_addr;
            req_wdata = rom_data;
        end else if (state == S_LSN_WR) begin
            req_addr  = REG_SCMD;
            req_wdata = CMD_LISTEN;
        end
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rst_n |-> (!req_valid && !ready));

    p_release_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n) |-> !req_valid);

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(req_ack) && ($past(ack_rdata) == CODE_EST)));

    p_ready_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(req_ack));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_write)
                                     && $stable(req_addr) && $stable(req_wdata)));

endmodule

// File: tb/sock_bringup_sup_tb_top.sv
// Bench for the socket bring-up supervisor: an access-engine responder
// with a write scoreboard and a status script, a vector table for the
// supervising phase, and directed checks for reset timing and re-bring-up.
module sock_bringup_sup_tb_top;

    localparam int          TB_CLK_HZ = 4000;
    localparam int          TB_CPM    = TB_CLK_HZ / 1000;
    localparam int          LOW_CYC   = 50 * TB_CPM;
    localparam int          SET_CYC   = 5 * TB_CPM;
    localparam int          LAT       = 2;
    localparam int          NWR       = 25;
    localparam logic [47:0] T_MAC     = 48'h02_11_22_33_44_55;
    localparam logic [31:0] T_IP      = 32'h0A00_0005;
    localparam logic [31:0] T_MASK    = 32'hFFFF_FF00;
    localparam logic [31:0] T_GW      = 32'h0A00_0001;

    // {first status, second status, re-read expected, ready, reset}
    localparam int NVEC = 7;
    localparam logic [18:0] VEC [NVEC] = '{
        {8'h17, 8'h00, 1'b0, 1'b1, 1'b0},
        {8'h14, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h17, 8'h00, 1'b0, 1'b1, 1'b0},
        {8'h00, 8'h17, 1'b1, 1'b1, 1'b0},
        {8'h1C, 8'h14, 1'b1, 1'b0, 1'b0},
        {8'h17, 8'h00, 1'b0, 1'b1, 1'b0},
        {8'h13, 8'h22, 1'b1, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, ctrl_rst_n, ready;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ack;
    logic [7:0]  ack_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int n_wr  = 0;
    int n_rd  = 0;
    int lat_cnt = 0;
    int rd_at_listen = -1;
    logic [7:0]  stat_dflt;
    logic [7:0]  stat_q[$];
    logic [15:0] ea [NWR];
    logic [7:0]  ed [NWR];

    always #10 clk = ~clk;

    sock_bringup_sup #(
        .CLK_HZ     (TB_CLK_HZ),
        .STATION_MAC(T_MAC),
        .STATION_IP (T_IP),
        .NET_MASK   (T_MASK),
        .GATEWAY_IP (T_GW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ack   (req_ack),
        .ack_rdata (ack_rdata),
        .ctrl_rst_n(ctrl_rst_n),
        .ready     (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Access-engine model: acknowledges after LAT cycles, scores writes.
    always @(negedge clk) begin
        if (req_ack) begin
            req_ack = 1'b0;
        end else if (rst_n && req_valid) begin
            if (lat_cnt == LAT) begin
                lat_cnt = 0;
                req_ack = 1'b1;
                if (req_write) begin
                    chk(req_addr == ea[n_wr % NWR], "R3/R4 write addr", int'(req_addr), int'(ea[n_wr % NWR]));
                    chk(req_wdata == ed[n_wr % NWR], "R3/R4 write data", int'(req_wdata), int'(ed[n_wr % NWR]));
                    if ((n_wr % NWR) == NWR - 1) rd_at_listen = n_rd;
                    n_wr++;
                end else begin
                    chk(req_addr == 16'h0403, "R5 status addr", int'(req_addr), 16'h0403);
                    if (stat_q.size() > 0) ack_rdata = stat_q.pop_front();
                    else                   ack_rdata = stat_dflt;
                    n_rd++;
                end
            end else begin
                lat_cnt++;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        int base;
        // Expected bring-up write list, built from the requirements.
        for (int i = 0; i < 6; i++) begin
            ea[i] = 16'h0009 + 16'(i);
            ed[i] = T_MAC[8*(5-i) +: 8];
        end
        for (int i = 0; i < 4; i++) begin
            ea[6+i]  = 16'h000F + 16'(i);
            ed[6+i]  = T_IP[8*(3-i) +: 8];
            ea[10+i] = 16'h0005 + 16'(i);
            ed[10+i] = T_MASK[8*(3-i) +: 8];
            ea[14+i] = 16'h0001 + 16'(i);
            ed[14+i] = T_GW[8*(3-i) +: 8];
        end
        ea[18] = 16'h001A; ed[18] = 8'h0A;
        ea[19] = 16'h001B; ed[19] = 8'h0A;
        ea[20] = 16'h0400; ed[20] = 8'h01;
        ea[21] = 16'h0404; ed[21] = 8'h13;
        ea[22] = 16'h0405; ed[22] = 8'h88;
        ea[23] = 16'h0401; ed[23] = 8'h01;
        ea[24] = 16'h0401; ed[24] = 8'h02;

        // Bring-up status script: two non-INIT polls, INIT, then one
        // non-LISTEN poll and LISTEN.
        stat_q.push_back(8'h00);
        stat_q.push_back(8'h22);
        stat_q.push_back(8'h13);
        stat_q.push_back(8'h13);
        stat_q.push_back(8'h14);
        stat_dflt = 8'h14;
        req_ack   = 1'b0;
        ack_rdata = 8'h00;
        rst_n     = 1'b0;

        repeat (4) @(negedge clk);
        chk(ctrl_rst_n == 1'b0, "R1 reset state ctrl_rst_n", int'(ctrl_rst_n), 0);
        chk(ready == 1'b0, "R1 reset state ready", int'(ready), 0);
        chk(req_valid == 1'b0, "R1 reset state req_valid", int'(req_valid), 0);

        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ctrl_rst_n && n < 100000);
        chk(n == LOW_CYC, "R1 reset-low length", n, LOW_CYC);

        n = 0;
        while (!req_valid && n < 100000) begin
            @(negedge clk);
            n++;
        end
        chk(n == SET_CYC, "R2 settle length", n, SET_CYC);

        wait (n_wr == NWR);
        chk(rd_at_listen == 3, "R5 reads before LISTEN command", rd_at_listen, 3);
        wait (n_rd == 5);
        @(negedge clk);
        chk(ready == 1'b0, "R6 ready low after bring-up", int'(ready), 0);
        chk(n_wr == NWR, "R6 no extra writes", n_wr, NWR);

        // Supervising phase: walk the vector table.
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] s1, s2;
            logic       two, rdy, rs;
            {s1, s2, two, rdy, rs} = VEC[v];
            @(posedge clk);
            base = n_rd;
            stat_q.push_back(s1);
            if (two) stat_q.push_back(s2);
            if (rs) begin
                stat_q.push_back(8'h13);
                stat_q.push_back(8'h14);
                stat_dflt = 8'h14;
            end else begin
                stat_dflt = rdy ? 8'h17 : 8'h14;
            end
            wait (n_rd == base + (two ? 2 : 1));
            @(negedge clk);
            chk(ready == rdy, two ? "R9/R10 ready after re-read" : "R7/R8 ready after read",
                int'(ready), int'(rdy));
            chk(ctrl_rst_n == !rs, "R9/R10 reset decision", int'(ctrl_rst_n), int'(!rs));
            if (!rs) chk(n_rd == base + (two ? 2 : 1), "R9 single re-read", n_rd, base + (two ? 2 : 1));
        end

        // R10: second reset pulse and full reconfiguration.
        n = 0;
        while (!ctrl_rst_n && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(n == LOW_CYC, "R10 repeated reset-low length", n, LOW_CYC);
        base = n_rd;
        wait (n_wr == 2 * NWR);
        wait (n_rd == base + 2);
        @(negedge clk);
        chk(ready == 1'b0, "R10 ready low after re-bring-up", int'(ready), 0);
        @(posedge clk);
        base = n_rd;
        stat_q.push_back(8'h17);
        stat_dflt = 8'h17;
        wait (n_rd == base + 1);
        @(negedge clk);
        chk(ready == 1'b1, "R10 supervision resumes", int'(ready), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule